// File: doc/BRIEF.md
# Accumulator CPU Register-Only Execute Stage

This block is the execute stage of a small 8-bit accumulator machine. It holds the architectural state: the accumulator A, the index registers X and Y, the stack pointer S, and six status flags. The block covers only the instructions that need no memory access. An upstream fetch stage offers one opcode byte, together with an immediate byte and a status byte, through a valid/ready handshake. The stage then runs the instruction for a fixed number of cycles. It pulses `done` in the last of those cycles, and it commits the new register and flag values at the end of that same cycle.

The instruction set is made up of three groups. The first group is register copies. The second is an immediate load. The third is a set of fused immediate operations: AND with carry set from bit 7, AND followed by a rotate, AND-then-subtract into X, and subtract with borrow. There is also a status restore, which takes its value from the `stat_in` port instead of from stack memory. Each instruction has its own flag rules. The copy into the stack pointer touches no flag. Any opcode outside the set runs as a two-cycle no-operation.

Top module: `acc_exec_core`

## Requirements
- R1: After a synchronous active-low reset, A, X and Y read 0, S reads FF, `status` reads 00, `op_ready` is 1 and `done` is 0.
- R2: An instruction is accepted in a cycle where `op_valid` and `op_ready` are both 1. `op_ready` is 0 from the next cycle until `done` has been seen. `done` is high for exactly one cycle, and `op_ready` returns to 1 in the cycle after `done`.
- R3: The accept cycle counts as cycle 1. `done` is high in cycle 2 for every opcode except 28, where `done` is high in cycle 4. New register and flag values are visible from the cycle after `done`.
- R4: Opcodes AA (A to X), 8A (X to A), A8 (A to Y), 98 (Y to A) and BA (S to X) copy the register. They set N from bit 7 of the copied value and set Z when that value is zero. V, D, I and C keep their values.
- R5: Opcode 9A copies X into S and leaves all six flags unchanged.
- R6: Opcode A9 loads the immediate byte into A and updates N and Z from it.
- R7: Opcodes 0B and 2B both write A AND imm into A. They update N and Z from the result and set C equal to bit 7 of the result.
- R8: Opcode 6B forms A AND imm, then shifts it right one place with the old C entering bit 7, and writes the result to A. It sets N and Z from the result, C from result bit 6, and V from result bit 6 XOR bit 5.
- R9: Opcode CB writes (A AND X) minus imm, modulo 256, into X. C is 1 when (A AND X) >= imm as unsigned values. N and Z come from the 8-bit difference, and V is unchanged.
- R10: Opcode EB writes A - imm - (1 - C) into A, modulo 256, in binary even when D is set. C is 1 when no borrow occurs. V is 1 on signed overflow. N and Z come from the result.
- R11: Opcode 28 loads N, V, D, I, Z and C from `stat_in` as sampled in the accept cycle. It uses the same bit positions as `status`, and ignores `stat_in` bits 5 and 4.
- R12: An opcode outside R4 to R11 completes in 2 cycles and changes no register and no flag.
- R13: The `status` port carries N on bit 7, V on bit 6, D on bit 3, I on bit 2, Z on bit 1 and C on bit 0. Bits 5 and 4 always read 0.
- R14: `op_valid`, `op_code`, `op_imm` and `stat_in` have no effect while `op_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An opcode is offered |
| op_ready | output | 1 | The stage is idle and can accept an opcode |
| op_code | input | 8 | Opcode byte |
| op_imm | input | 8 | Immediate operand byte |
| stat_in | input | 8 | Status byte for the status restore, in the `status` layout |
| done | output | 1 | One-cycle pulse in the last cycle of an instruction |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | Index register X |
| reg_y | output | 8 | Index register Y |
| reg_s | output | 8 | Stack pointer |
| status | output | 8 | Status flags, layout as in R13 |

## Verification
All architectural state is visible at the ports, so a wrong register or flag appears in the cycle right after the `done` of the instruction that produced it. A wrong cycle count appears as `done` arriving early or late relative to the accept cycle. A stale or corrupted flag that no instruction rewrites shows up only when a later flag-preserving instruction, such as the stack-pointer copy or a no-operation, is checked against the full status byte. For that reason, the sequences interleave flag-preserving opcodes with flag-setting ones and compare all eight status bits every time.

// File: rtl/aec_pkg.sv
// Shared definitions for the accumulator execute stage.
// Assumes an 8-bit data path; opcode encodings are fixed byte values.
package aec_pkg;

    localparam int DW = 8;

    // Operation classes the decoder maps opcode bytes onto.
    typedef enum logic [3:0] {
        K_NOP,
        K_A2X,
        K_X2A,
        K_A2Y,
        K_Y2A,
        K_S2X,
        K_X2S,
        K_LDI,
        K_ANDC,
        K_ANDR,
        K_ANDSX,
        K_SBCI,
        K_PULLP
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [DW-1:0] s;
        flags_t        p;
    } arch_t;

    localparam logic [DW-1:0] OPC_A2X   = 8'hAA;
    localparam logic [DW-1:0] OPC_X2A   = 8'h8A;
    localparam logic [DW-1:0] OPC_A2Y   = 8'hA8;
    localparam logic [DW-1:0] OPC_Y2A   = 8'h98;
    localparam logic [DW-1:0] OPC_S2X   = 8'hBA;
    localparam logic [DW-1:0] OPC_X2S   = 8'h9A;
    localparam logic [DW-1:0] OPC_LDI   = 8'hA9;
    localparam logic [DW-1:0] OPC_ANDC0 = 8'h0B;
    localparam logic [DW-1:0] OPC_ANDC1 = 8'h2B;
    localparam logic [DW-1:0] OPC_ANDR  = 8'h6B;
    localparam logic [DW-1:0] OPC_ANDSX = 8'hCB;
    localparam logic [DW-1:0] OPC_SBCI  = 8'hEB;
    localparam logic [DW-1:0] OPC_PULLP = 8'h28;

    // Bit positions of the flags inside the status byte.
    localparam int PB_N = 7;
    localparam int PB_V = 6;
    localparam int PB_D = 3;
    localparam int PB_I = 2;
    localparam int PB_Z = 1;
    localparam int PB_C = 0;

    // Lay the flags out into a status byte; unused bits read zero.
    function automatic logic [DW-1:0] pack_status(input flags_t f);
        logic [DW-1:0] b;
        b       = '0;
        b[PB_N] = f.n;
        b[PB_V] = f.v;
        b[PB_D] = f.d;
        b[PB_I] = f.i;
        b[PB_Z] = f.z;
        b[PB_C] = f.c;
        return b;
    endfunction

    // Extract the six flags from a status byte; unused bits are dropped.
    function automatic flags_t unpack_status(input logic [DW-1:0] b);
        flags_t f;
        f.n = b[PB_N];
        f.v = b[PB_V];
        f.d = b[PB_D];
        f.i = b[PB_I];
        f.z = b[PB_Z];
        f.c = b[PB_C];
        return f;
    endfunction

endpackage

// File: rtl/aec_decode.sv
// Opcode decoder: maps an opcode byte onto an operation class and a
// cycle count. Assumes every cycle count fits in CNT_W bits and is >= 2.
module aec_decode
    import aec_pkg::*;
#(
    parameter int BASE_CYC = 2,
    parameter int PULL_CYC = 4,
    parameter int CNT_W    = 3
) (
    input  logic [DW-1:0]    opc,
    output op_kind_e         kind,
    output logic [CNT_W-1:0] cycles
);

    // Classify the opcode; unlisted bytes become a no-operation.
    always_comb begin
        case (opc)
            OPC_A2X:   kind = K_A2X;
            OPC_X2A:   kind = K_X2A;
            OPC_A2Y:   kind = K_A2Y;
            OPC_Y2A:   kind = K_Y2A;
            OPC_S2X:   kind = K_S2X;
            OPC_X2S:   kind = K_X2S;
            OPC_LDI:   kind = K_LDI;
            OPC_ANDC0: kind = K_ANDC;
            OPC_ANDC1: kind = K_ANDC;
            OPC_ANDR:  kind = K_ANDR;
            OPC_ANDSX: kind = K_ANDSX;
            OPC_SBCI:  kind = K_SBCI;
            OPC_PULLP: kind = K_PULLP;
            default:   kind = K_NOP;
        endcase
    end

    // Pick the instruction length; only the status restore is longer.
    always_comb begin
        if (kind == K_PULLP) cycles = CNT_W'(PULL_CYC);
        else                 cycles = CNT_W'(BASE_CYC);
    end

endmodule

// File: rtl/aec_seq.sv
// Handshake and cycle sequencer. Accepts an instruction while idle,
// counts its length down and flags the final cycle.
// Assumes cycles_in >= 2 whenever an instruction is accepted.
module aec_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] cycles_in,
    output logic             ready,
    output logic             accept,
    output logic             last
);

    logic             busy;
    logic [CNT_W-1:0] remain;

    assign ready  = !busy;
    assign accept = req_valid && !busy;
    assign last   = busy && (remain == CNT_W'(1));

    // Track whether an instruction is in flight and how many cycles remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            remain <= cycles_in - CNT_W'(1);
        end else if (busy) begin
            if (last) busy <= 1'b0;
            remain <= remain - CNT_W'(1);
        end
    end

endmodule

// File: rtl/aec_alu.sv
// Next-state logic: from the current architectural state, the operation
// class and its operands, computes the state to be committed.
// Purely combinational; all arithmetic is binary regardless of the D flag.
module aec_alu
    import aec_pkg::*;
(
    input  op_kind_e      kind,
    input  arch_t         cur,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] stat,
    output arch_t         nxt
);

    logic [DW-1:0] and_ai;
    logic [DW-1:0] and_ax;
    logic [DW-1:0] rot;
    logic [DW:0]   dif;
    logic [DW:0]   sum;
    logic [DW-1:0] res;
    logic          upd_nz;

    // Operands shared by the fused immediate operations.
    always_comb begin
        and_ai = cur.a & imm;
        and_ax = cur.a & cur.x;
        rot    = {cur.p.c, and_ai[DW-1:1]};
        dif    = {1'b0, and_ax} - {1'b0, imm};
        sum    = {1'b0, cur.a} + {1'b0, ~imm} + {{DW{1'b0}}, cur.p.c};
    end

    // Select the written register and flags for each operation class.
    always_comb begin
        nxt    = cur;
        res    = '0;
        upd_nz = 1'b0;
        case (kind)
            K_A2X: begin
                nxt.x  = cur.a;
                res    = cur.a;
                upd_nz = 1'b1;
            end
            K_X2A: begin
                nxt.a  = cur.x;
                res    = cur.x;
                upd_nz = 1'b1;
            end
            K_A2Y: begin
                nxt.y  = cur.a;
                res    = cur.a;
                upd_nz = 1'b1;
            end
            K_Y2A: begin
                nxt.a  = cur.y;
                res    = cur.y;
                upd_nz = 1'b1;
            end
            K_S2X: begin
                nxt.x  = cur.s;
                res    = cur.s;
                upd_nz = 1'b1;
            end
            K_X2S: begin
                nxt.s = cur.x;
            end
            K_LDI: begin
                nxt.a  = imm;
                res    = imm;
                upd_nz = 1'b1;
            end
            K_ANDC: begin
                nxt.a   = and_ai;
                res     = and_ai;
                upd_nz  = 1'b1;
                nxt.p.c = and_ai[DW-1];
            end
            K_ANDR: begin
                nxt.a   = rot;
                res     = rot;
                upd_nz  = 1'b1;
                nxt.p.c = rot[DW-2];
                nxt.p.v = rot[DW-2] ^ rot[DW-3];
            end
            K_ANDSX: begin
                nxt.x   = dif[DW-1:0];
                res     = dif[DW-1:0];
                upd_nz  = 1'b1;
                nxt.p.c = ~dif[DW];
            end
            K_SBCI: begin
                nxt.a   = sum[DW-1:0];
                res     = sum[DW-1:0];
                upd_nz  = 1'b1;
                nxt.p.c = sum[DW];
                nxt.p.v = (cur.a[DW-1] ^ imm[DW-1]) & (cur.a[DW-1] ^ sum[DW-1]);
            end
            K_PULLP: begin
                nxt.p = unpack_status(stat);
            end
            default: begin
                nxt = cur;
            end
        endcase
        if (upd_nz) begin
            nxt.p.n = res[DW-1];
            nxt.p.z = (res == '0);
        end
    end

endmodule

// File: rtl/acc_exec_core.sv
// Top of the execute stage. Holds A, X, Y, S and the flags, latches the
// offered instruction on accept and commits the computed state in the
// final cycle. Assumes fetch, memory and stack storage live elsewhere.
module acc_exec_core
    import aec_pkg::*;
#(
    parameter int BASE_CYC = 2,
    parameter int PULL_CYC = 4,
    parameter logic [DW-1:0] S_RESET = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic [DW-1:0] op_code,
    input  logic [DW-1:0] op_imm,
    input  logic [DW-1:0] stat_in,
    output logic          done,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_x,
    output logic [DW-1:0] reg_y,
    output logic [DW-1:0] reg_s,
    output logic [DW-1:0] status
);

    localparam int MAX_CYC = (PULL_CYC > BASE_CYC) ? PULL_CYC : BASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    op_kind_e         dec_kind;
    logic [CNT_W-1:0] dec_cycles;
    logic             accept;
    op_kind_e         kind_q;
    logic [DW-1:0]    imm_q;
    logic [DW-1:0]    stat_q;
    arch_t            arch_q;
    arch_t            arch_d;

    aec_decode #(
        .BASE_CYC (BASE_CYC),
        .PULL_CYC (PULL_CYC),
        .CNT_W    (CNT_W)
    ) u_dec (
        .opc    (op_code),
        .kind   (dec_kind),
        .cycles (dec_cycles)
    );

    aec_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (op_valid),
        .cycles_in (dec_cycles),
        .ready     (op_ready),
        .accept    (accept),
        .last      (done)
    );

    aec_alu u_alu (
        .kind (kind_q),
        .cur  (arch_q),
        .imm  (imm_q),
        .stat (stat_q),
        .nxt  (arch_d)
    );

    // Capture the operation class and its operands on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_NOP;
            imm_q  <= '0;
            stat_q <= '0;
        end else if (accept) begin
            kind_q <= dec_kind;
            imm_q  <= op_imm;
            stat_q <= stat_in;
        end
    end

    // Commit the architectural state at the end of the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_q.a <= '0;
            arch_q.x <= '0;
            arch_q.y <= '0;
            arch_q.s <= S_RESET;
            arch_q.p <= '0;
        end else if (done) begin
            arch_q <= arch_d;
        end
    end

    assign reg_a  = arch_q.a;
    assign reg_x  = arch_q.x;
    assign reg_y  = arch_q.y;
    assign reg_s  = arch_q.s;
    assign status = pack_status(arch_q.p);

endmodule

// File: rtl/aec_chk.sv
// Protocol and flag-rule checker for the execute stage, bound to its top.
module aec_chk
    import aec_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic          op_ready,
    input logic [DW-1:0] op_code,
    input logic          done,
    input logic [DW-1:0] reg_a,
    input logic [DW-1:0] reg_x,
    input logic [DW-1:0] reg_y,
    input logic [DW-1:0] reg_s,
    input logic [DW-1:0] status,
    input op_kind_e      kind_q
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (reg_a == '0 && reg_x == '0 && reg_y == '0 &&
                           reg_s == 8'hFF && status == '0 && op_ready && !done));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_ready);

    // R2
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !op_ready);

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> op_ready);

    // R3
    pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_code == OPC_PULLP) |=> !done ##1 !done ##1 done);

    // R3
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_code != OPC_PULLP) |=> done);

    // R5
    x2s_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_q == K_X2S) |=> ($stable(status) && reg_s == $past(reg_x)));

    // R13
    status_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:4] == 2'b00);

endmodule

bind acc_exec_core aec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op_code  (op_code),
    .done     (done),
    .reg_a    (reg_a),
    .reg_x    (reg_x),
    .reg_y    (reg_y),
    .reg_s    (reg_s),
    .status   (status),
    .kind_q   (kind_q)
);

// File: tb/sim_acc_exec_core.sv
// Scoreboard bench: the driver models each instruction and queues the
// expected state; the monitor checks length and state at each done.
module sim_acc_exec_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_ready;
    logic [7:0] op_code = 8'h00;
    logic [7:0] op_imm = 8'h00;
    logic [7:0] stat_in = 8'h00;
    logic       done;
    logic [7:0] reg_a, reg_x, reg_y, reg_s, status;

    always #5 clk = ~clk;

    acc_exec_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_ready (op_ready),
        .op_code  (op_code),
        .op_imm   (op_imm),
        .stat_in  (stat_in),
        .done     (done),
        .reg_a    (reg_a),
        .reg_x    (reg_x),
        .reg_y    (reg_y),
        .reg_s    (reg_s),
        .status   (status)
    );

    typedef struct {
        logic [7:0] a, x, y, s, p;
        int         len;
        int         acc;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   finished = 0;

    // Bench model of the architectural state.
    logic [7:0] m_a = 0, m_x = 0, m_y = 0, m_s = 8'hFF;
    logic m_n = 0, m_v = 0, m_d = 0, m_i = 0, m_z = 0, m_c = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_stat();
        return {m_n, m_v, 2'b00, m_d, m_i, m_z, m_c};
    endfunction

    task automatic set_nz(input logic [7:0] r);
        m_n = r[7];
        m_z = (r == 8'h00);
    endtask

    // Drive one instruction, holding noise on the inputs while busy (R14).
    task automatic issue(input logic [7:0] opc, input logic [7:0] imm,
                         input logic [7:0] st, input string tag);
        exp_t e;
        int   len;
        logic [7:0] t;
        int   sd;
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        len = (opc == 8'h28) ? 4 : 2;
        case (opc)
            8'hAA: begin m_x = m_a; set_nz(m_x); end
            8'h8A: begin m_a = m_x; set_nz(m_a); end
            8'hA8: begin m_y = m_a; set_nz(m_y); end
            8'h98: begin m_a = m_y; set_nz(m_a); end
            8'hBA: begin m_x = m_s; set_nz(m_x); end
            8'h9A: m_s = m_x;
            8'hA9: begin m_a = imm; set_nz(m_a); end
            8'h0B, 8'h2B: begin m_a = m_a & imm; set_nz(m_a); m_c = m_a[7]; end
            8'h6B: begin
                t = m_a & imm;
                m_a = (t >> 1) | {m_c, 7'b0};
                set_nz(m_a);
                m_c = m_a[6];
                m_v = m_a[6] ^ m_a[5];
            end
            8'hCB: begin
                t = m_a & m_x;
                m_c = (t >= imm);
                m_x = t - imm;
                set_nz(m_x);
            end
            8'hEB: begin
                sd = int'($signed(m_a)) - int'($signed(imm)) - (m_c ? 0 : 1);
                m_v = (sd < -128) || (sd > 127);
                m_c = (int'(m_a) - int'(imm) - (m_c ? 0 : 1)) >= 0;
                m_a = 8'(sd);
                set_nz(m_a);
            end
            8'h28: begin
                m_n = st[7]; m_v = st[6]; m_d = st[3];
                m_i = st[2]; m_z = st[1]; m_c = st[0];
            end
            default: ;
        endcase
        e.a = m_a; e.x = m_x; e.y = m_y; e.s = m_s; e.p = m_stat();
        e.len = len; e.acc = cyc; e.tag = tag;
        q.push_back(e);
        op_valid = 1'b1; op_code = opc; op_imm = imm; stat_in = st;
        for (int c = 2; c <= len; c++) begin
            @(negedge clk);
            chk(!op_ready, {tag, " R2 ready low while busy"}, op_ready, 0);
            op_valid = (c < len);
            op_code  = 8'hA9;
            op_imm   = 8'h5A;
            stat_in  = 8'hFF;
        end
    endtask

    // Monitor: at done check length (R3), the cycle after check state.
    initial begin
        exp_t cur;
        bit   pend = 0;
        forever begin
            @(negedge clk);
            if (pend) begin
                pend = 0;
                chk(op_ready, {cur.tag, " R2 ready after done"}, op_ready, 1);
                chk(reg_a == cur.a, {cur.tag, " A"}, reg_a, cur.a);
                chk(reg_x == cur.x, {cur.tag, " X"}, reg_x, cur.x);
                chk(reg_y == cur.y, {cur.tag, " Y"}, reg_y, cur.y);
                chk(reg_s == cur.s, {cur.tag, " S"}, reg_s, cur.s);
                chk(status == cur.p, {cur.tag, " status R13"}, status, cur.p);
            end
            if (done && rst_n) begin
                if (q.size() == 0) begin
                    chk(0, "R2 done with nothing issued", 1, 0);
                end else begin
                    cur = q.pop_front();
                    chk(cyc - cur.acc + 1 == cur.len, {cur.tag, " R3 length"},
                        cyc - cur.acc + 1, cur.len);
                    pend = 1;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_a == 0 && reg_x == 0 && reg_y == 0, "R1 A/X/Y zero", {reg_a, reg_x, reg_y}, 0);
        chk(reg_s == 8'hFF, "R1 S", reg_s, 8'hFF);
        chk(status == 8'h00, "R1 status", status, 0);
        chk(op_ready && !done, "R1 ready/done", {op_ready, done}, 2);

        issue(8'hBA, 8'h00, 8'h00, "R4 S2X");
        issue(8'hA9, 8'h00, 8'h00, "R6 load zero");
        issue(8'h9A, 8'h00, 8'h00, "R5 X2S keeps flags");
        issue(8'hA9, 8'h80, 8'h00, "R6 load neg");
        issue(8'hAA, 8'h00, 8'h00, "R4 A2X");
        issue(8'hA9, 8'h3C, 8'h00, "R6 load");
        issue(8'hA8, 8'h00, 8'h00, "R4 A2Y");
        issue(8'hA9, 8'h00, 8'h00, "R6 load zero2");
        issue(8'h98, 8'h00, 8'h00, "R4 Y2A");
        issue(8'h8A, 8'h00, 8'h00, "R4 X2A");
        issue(8'h9A, 8'h00, 8'h00, "R5 X2S nonzero");
        issue(8'h0B, 8'hF0, 8'h00, "R7 and-carry 0B");
        issue(8'hA9, 8'hC3, 8'h00, "R6 reload");
        issue(8'h2B, 8'h83, 8'h00, "R7 and-carry 2B");
        issue(8'h6B, 8'hFF, 8'h00, "R8 and-rotate C=1");
        issue(8'hA9, 8'h60, 8'h00, "R6 reload2");
        issue(8'h6B, 8'h40, 8'h00, "R8 and-rotate");
        issue(8'hA9, 8'hFF, 8'h00, "R6 reload3");
        issue(8'hA2, 8'h00, 8'h00, "R12 unknown nop");
        issue(8'hCB, 8'h80, 8'h00, "R9 and-sub equal");
        issue(8'hA9, 8'h0F, 8'h00, "R6 reload4");
        issue(8'hAA, 8'h00, 8'h00, "R4 A2X 0F");
        issue(8'hCB, 8'h20, 8'h00, "R9 and-sub borrow");
        issue(8'h28, 8'h00, 8'hFF, "R11 pull all ones");
        issue(8'hA9, 8'h50, 8'h00, "R6 reload5");
        issue(8'hEB, 8'hB0, 8'h00, "R10 sbc overflow D set");
        issue(8'hEB, 8'h01, 8'h00, "R10 sbc");
        issue(8'h28, 8'h00, 8'h30, "R11 pull pad bits");
        issue(8'hA9, 8'h00, 8'h00, "R6 reload6");
        issue(8'hEB, 8'h00, 8'h00, "R10 sbc borrow in");
        issue(8'h02, 8'hFF, 8'hFF, "R12 unknown nop2");
        issue(8'h28, 8'h00, 8'hC5, "R11 pull mixed");
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R3 all instructions completed", q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule